// File: doc/BRIEF.md
# DMA Controller Register Interface

This block is the processor-facing programming port of a four-channel DMA controller. A 4-bit offset, a write strobe, a read strobe and an 8-bit data bus reach every register. Each channel keeps a 16-bit start address and a 16-bit transfer count, as a base copy and a current copy. Each channel also has a mode byte and a mask bit. A command byte and a latched terminal-count status are shared by all channels.

All data moves a byte at a time. Both 16-bit quantities of a channel share one offset. A single toggling byte-select bit, common to all channels, decides whether an access hits the low or the high half. Software puts this bit back to the low half with a dedicated write. The transfer engine reads the programmed values and masks from the output buses. It returns the live current address and count through an update strobe, and it reports terminal-count events and pending requests.

Top module: `dmareg_top`

## Requirements
- R1: After reset all four mask bits are 1, the byte-select bit selects the low byte, and the command, mode, status, base and current registers are all zero.
- R2: Every read or write of offsets 0x0–0x7 flips the byte-select bit, starting from the low byte. A write of any value to offset 0xC returns it to the low byte. Accesses to offsets 0x8–0xF do not flip it.
- R3: Offset 2n addresses channel n's address and offset 2n+1 its count (n = 0..3). A write stores the byte into the selected half of both the base and the current copy. A read returns the selected half of the current copy.
- R4: When `eng_upd[n]` is high, the current address and count of channel n take `eng_cur_addr`/`eng_cur_cnt` at the next edge and the base copies stay unchanged. A processor write to offset 2n or 2n+1 in the same cycle wins, and that engine update is dropped.
- R5: A write to offset 0xA with bits 1:0 = n sets mask n to data bit 2. The other masks are kept.
- R6: A write to offset 0xE clears all masks. A write to offset 0xF loads mask n from data bit n.
- R7: A write to offset 0xB stores data bits 7:2 as the 6-bit mode of the channel in bits 1:0, on `ch_mode[6n+5:6n]`. For example, 0x44 gives mode 0x11, 0xC0 gives 0x30, and setting 0x10 sets mode bit 2.
- R8: A write to offset 0x8 stores the data byte as the command, shown on `ch_cmd`.
- R9: A read of offset 0x8 returns the pending requests `eng_req` in bits 7:4 and the latched terminal-count flags in bits 3:0. A pulse on `eng_tc[n]` sets flag n. The read clears the flags, except those pulsing in that same cycle.
- R10: A write to offset 0xD resets the byte-select bit, command, status flags and modes, and sets all masks. Addresses and counts are kept.
- R11: Reads of offsets 0x9–0xF return 0x00 and change no state. A write to offset 0x9 has no effect. `cpu_rdata` is 0x00 whenever no read is made.
- R12: When `cpu_wr` and `cpu_rd` are both high, only the write takes place and the byte-select bit flips once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_off | input | 4 | Register offset |
| cpu_wr | input | 1 | Write strobe, one cycle per byte |
| cpu_rd | input | 1 | Read strobe, one cycle per byte |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid in the cycle `cpu_rd` is high |
| eng_tc | input | 4 | Terminal-count pulse per channel |
| eng_req | input | 4 | Pending request level per channel |
| eng_upd | input | 4 | Live-value update strobe per channel |
| eng_cur_addr | input | 64 | Live current address, 16 bits per channel |
| eng_cur_cnt | input | 64 | Live current count, 16 bits per channel |
| ch_base_addr | output | 64 | Programmed base address per channel |
| ch_base_cnt | output | 64 | Programmed base count per channel |
| ch_cur_addr | output | 64 | Current address per channel |
| ch_cur_cnt | output | 64 | Current count per channel |
| ch_mode | output | 24 | 6-bit mode per channel |
| ch_mask | output | 4 | Mask bit per channel, 1 = disabled |
| ch_cmd | output | 8 | Command byte |

## Verification
Two cases are hard to reach: a terminal-count pulse landing in the same cycle as a status read, and an engine update colliding with a processor write to the same channel. Directed cycles line up those coincidences on purpose. A long random phase then mixes accesses to all sixteen offsets without resetting the byte-select bit. Any missed or extra toggle would then put every later 16-bit readback out of step with the bench model.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;
    localparam int NCH    = 4;
    localparam int CH_W   = $clog2(NCH);
    localparam int AW     = 16;
    localparam int BYTE_W = 8;
    localparam int MODE_W = BYTE_W - CH_W;

    localparam logic [3:0] OFS_CMD     = 4'h8;
    localparam logic [3:0] OFS_MASK1   = 4'hA;
    localparam logic [3:0] OFS_MODE    = 4'hB;
    localparam logic [3:0] OFS_FFCLR   = 4'hC;
    localparam logic [3:0] OFS_MCLR    = 4'hD;
    localparam logic [3:0] OFS_UNMASK  = 4'hE;
    localparam logic [3:0] OFS_MASKALL = 4'hF;

    typedef struct packed {
        logic            ar_wr;
        logic            ar_rd;
        logic [CH_W-1:0] ar_ch;
        logic            ar_is_cnt;
        logic            cmd_wr;
        logic            stat_rd;
        logic            mask1_wr;
        logic            mode_wr;
        logic            ffclr_wr;
        logic            mclr_wr;
        logic            unmask_wr;
        logic            maskall_wr;
    } dec_t;
endpackage

// File: rtl/dmareg_decode.sv
module dmareg_decode
    import dmareg_pkg::*;
(
    input  logic [3:0] off,
    input  logic       wr,
    input  logic       rd,
    output dec_t       dec
);
    logic rd_only;
    logic is_ar;

    always_comb begin
        rd_only        = rd & ~wr;
        is_ar          = ~off[3];
        dec            = '0;
        dec.ar_wr      = wr & is_ar;
        dec.ar_rd      = rd_only & is_ar;
        dec.ar_ch      = off[CH_W:1];
        dec.ar_is_cnt  = off[0];
        dec.cmd_wr     = wr & (off == OFS_CMD);
        dec.stat_rd    = rd_only & (off == OFS_CMD);
        dec.mask1_wr   = wr & (off == OFS_MASK1);
        dec.mode_wr    = wr & (off == OFS_MODE);
        dec.ffclr_wr   = wr & (off == OFS_FFCLR);
        dec.mclr_wr    = wr & (off == OFS_MCLR);
        dec.unmask_wr  = wr & (off == OFS_UNMASK);
        dec.maskall_wr = wr & (off == OFS_MASKALL);
    end
endmodule

// File: rtl/dmareg_chan.sv
module dmareg_chan #(
    parameter int AW_P = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            is_cnt,
    input  logic            hi,
    input  logic [AW_P/2-1:0] wbyte,
    input  logic            upd,
    input  logic [AW_P-1:0] upd_addr,
    input  logic [AW_P-1:0] upd_cnt,
    output logic [AW_P-1:0] base_addr,
    output logic [AW_P-1:0] base_cnt,
    output logic [AW_P-1:0] cur_addr,
    output logic [AW_P-1:0] cur_cnt
);
    localparam int HB = AW_P / 2;

    typedef struct packed {
        logic [AW_P-1:0] base_addr;
        logic [AW_P-1:0] base_cnt;
        logic [AW_P-1:0] cur_addr;
        logic [AW_P-1:0] cur_cnt;
    } chan_st_t;

    chan_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (is_cnt) begin
                if (hi) begin
                    st_d.base_cnt[AW_P-1:HB] = wbyte;
                    st_d.cur_cnt[AW_P-1:HB]  = wbyte;
                end else begin
                    st_d.base_cnt[HB-1:0] = wbyte;
                    st_d.cur_cnt[HB-1:0]  = wbyte;
                end
            end else begin
                if (hi) begin
                    st_d.base_addr[AW_P-1:HB] = wbyte;
                    st_d.cur_addr[AW_P-1:HB]  = wbyte;
                end else begin
                    st_d.base_addr[HB-1:0] = wbyte;
                    st_d.cur_addr[HB-1:0]  = wbyte;
                end
            end
        end else if (upd) begin
            st_d.cur_addr = upd_addr;
            st_d.cur_cnt  = upd_cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign base_addr = st_q.base_addr;
    assign base_cnt  = st_q.base_cnt;
    assign cur_addr  = st_q.cur_addr;
    assign cur_cnt   = st_q.cur_cnt;
endmodule

// File: rtl/dmareg_top.sv
module dmareg_top
    import dmareg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [3:0]          cpu_off,
    input  logic                cpu_wr,
    input  logic                cpu_rd,
    input  logic [BYTE_W-1:0]   cpu_wdata,
    output logic [BYTE_W-1:0]   cpu_rdata,
    input  logic [NCH-1:0]      eng_tc,
    input  logic [NCH-1:0]      eng_req,
    input  logic [NCH-1:0]      eng_upd,
    input  logic [NCH*AW-1:0]   eng_cur_addr,
    input  logic [NCH*AW-1:0]   eng_cur_cnt,
    output logic [NCH*AW-1:0]   ch_base_addr,
    output logic [NCH*AW-1:0]   ch_base_cnt,
    output logic [NCH*AW-1:0]   ch_cur_addr,
    output logic [NCH*AW-1:0]   ch_cur_cnt,
    output logic [NCH*MODE_W-1:0] ch_mode,
    output logic [NCH-1:0]      ch_mask,
    output logic [BYTE_W-1:0]   ch_cmd
);
    typedef struct packed {
        logic                        ff;
        logic [NCH-1:0]              mask;
        logic [BYTE_W-1:0]           cmd;
        logic [NCH-1:0]              tc;
        logic [NCH-1:0][MODE_W-1:0]  mode;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    dec_t dec;
    logic byte_hi;

    logic [AW-1:0] cur_addr_a [NCH];
    logic [AW-1:0] cur_cnt_a  [NCH];
    logic [AW-1:0] rd_word;

    dmareg_decode u_dec (
        .off (cpu_off),
        .wr  (cpu_wr),
        .rd  (cpu_rd),
        .dec (dec)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        dmareg_chan #(.AW_P(AW)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (dec.ar_wr && (dec.ar_ch == CH_W'(ch))),
            .is_cnt    (dec.ar_is_cnt),
            .hi        (ctl_q.ff),
            .wbyte     (cpu_wdata),
            .upd       (eng_upd[ch]),
            .upd_addr  (eng_cur_addr[ch*AW +: AW]),
            .upd_cnt   (eng_cur_cnt[ch*AW +: AW]),
            .base_addr (ch_base_addr[ch*AW +: AW]),
            .base_cnt  (ch_base_cnt[ch*AW +: AW]),
            .cur_addr  (cur_addr_a[ch]),
            .cur_cnt   (cur_cnt_a[ch])
        );
        assign ch_cur_addr[ch*AW +: AW]      = cur_addr_a[ch];
        assign ch_cur_cnt[ch*AW +: AW]       = cur_cnt_a[ch];
        assign ch_mode[ch*MODE_W +: MODE_W]  = ctl_q.mode[ch];
    end

    // read path
    always_comb begin
        rd_word = dec.ar_is_cnt ? cur_cnt_a[dec.ar_ch] : cur_addr_a[dec.ar_ch];
        if (dec.ar_rd)
            cpu_rdata = ctl_q.ff ? rd_word[AW-1:AW/2] : rd_word[AW/2-1:0];
        else if (dec.stat_rd)
            cpu_rdata = {eng_req, ctl_q.tc};
        else
            cpu_rdata = '0;
    end

    // control next state
    always_comb begin
        ctl_d = ctl_q;
        if (dec.ar_wr || dec.ar_rd) ctl_d.ff = ~ctl_q.ff;
        if (dec.ffclr_wr)           ctl_d.ff = 1'b0;
        if (dec.cmd_wr)             ctl_d.cmd = cpu_wdata;
        if (dec.stat_rd)            ctl_d.tc = '0;
        if (dec.mask1_wr)           ctl_d.mask[cpu_wdata[CH_W-1:0]] = cpu_wdata[CH_W];
        if (dec.mode_wr)            ctl_d.mode[cpu_wdata[CH_W-1:0]] = cpu_wdata[BYTE_W-1:CH_W];
        if (dec.unmask_wr)          ctl_d.mask = '0;
        if (dec.maskall_wr)         ctl_d.mask = cpu_wdata[NCH-1:0];
        if (dec.mclr_wr) begin
            ctl_d.ff   = 1'b0;
            ctl_d.cmd  = '0;
            ctl_d.tc   = '0;
            ctl_d.mode = '0;
            ctl_d.mask = '1;
        end
        ctl_d.tc = ctl_d.tc | eng_tc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.mask <= '1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ch_mask = ctl_q.mask;
    assign ch_cmd  = ctl_q.cmd;
    assign byte_hi = ctl_q.ff;
endmodule

// File: rtl/dmareg_chk.sv
module dmareg_chk
    import dmareg_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic [3:0]            cpu_off,
    input logic                  cpu_wr,
    input logic                  cpu_rd,
    input logic [BYTE_W-1:0]     cpu_wdata,
    input logic [BYTE_W-1:0]     cpu_rdata,
    input logic [NCH-1:0]        ch_mask,
    input logic [NCH*MODE_W-1:0] ch_mode,
    input logic                  byte_hi
);
    a_r2_ff_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_off == OFS_FFCLR) |=> !byte_hi);

    a_r2_ff_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !cpu_off[3]) |=> (byte_hi != $past(byte_hi)));

    a_r5_single_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_off == OFS_MASK1)
        |=> (ch_mask[$past(cpu_wdata[CH_W-1:0])] == $past(cpu_wdata[CH_W])));

    a_r6_unmask_all: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_off == OFS_UNMASK) |=> (ch_mask == '0));

    a_r10_master_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_off == OFS_MCLR) |=> (ch_mask == '1 && !byte_hi && ch_mode == '0));

    a_r11_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_off > OFS_CMD) |-> (cpu_rdata == '0));

    a_r11_idle_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_rd) |-> (cpu_rdata == '0));

    for (genvar i = 0; i < NCH; i++) begin : g_mode
        a_r7_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
            (cpu_wr && cpu_off == OFS_MODE && cpu_wdata[CH_W-1:0] == CH_W'(i))
            |=> (ch_mode[i*MODE_W +: MODE_W] == $past(cpu_wdata[BYTE_W-1:CH_W])));
    end
endmodule

bind dmareg_top dmareg_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_off   (cpu_off),
    .cpu_wr    (cpu_wr),
    .cpu_rd    (cpu_rd),
    .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata),
    .ch_mask   (ch_mask),
    .ch_mode   (ch_mode),
    .byte_hi   (byte_hi)
);

// File: tb/dmareg_top_test.sv
`timescale 1ns/1ps
module dmareg_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cpu_off = '0;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic [3:0]  eng_tc = '0;
    logic [3:0]  eng_req = '0;
    logic [3:0]  eng_upd = '0;
    logic [63:0] eng_cur_addr = '0;
    logic [63:0] eng_cur_cnt = '0;
    logic [63:0] ch_base_addr, ch_base_cnt, ch_cur_addr, ch_cur_cnt;
    logic [23:0] ch_mode;
    logic [3:0]  ch_mask;
    logic [7:0]  ch_cmd;

    int checks = 0;
    int fails  = 0;

    // bench model
    logic [15:0] m_ba [4];
    logic [15:0] m_bc [4];
    logic [15:0] m_ca [4];
    logic [15:0] m_cc [4];
    logic [5:0]  m_mode [4];
    logic [3:0]  m_mask;
    logic [7:0]  m_cmd;
    logic [3:0]  m_tc;
    logic        m_ff;

    always #2 clk = ~clk;

    dmareg_top uut (
        .clk(clk), .rst_n(rst_n), .cpu_off(cpu_off), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .eng_tc(eng_tc), .eng_req(eng_req),
        .eng_upd(eng_upd), .eng_cur_addr(eng_cur_addr), .eng_cur_cnt(eng_cur_cnt),
        .ch_base_addr(ch_base_addr), .ch_base_cnt(ch_base_cnt), .ch_cur_addr(ch_cur_addr),
        .ch_cur_cnt(ch_cur_cnt), .ch_mode(ch_mode), .ch_mask(ch_mask), .ch_cmd(ch_cmd)
    );

    function automatic logic [7:0] exp_rd(input logic [3:0] off, input logic [3:0] req);
        logic [15:0] w;
        if (!off[3]) begin
            w = off[0] ? m_cc[off[2:1]] : m_ca[off[2:1]];
            return m_ff ? w[15:8] : w[7:0];
        end
        if (off == 4'h8) return {req, m_tc};
        return 8'h00;
    endfunction

    task automatic check8(input string tag, input string what, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin
            m_ba[i] = '0; m_bc[i] = '0; m_ca[i] = '0; m_cc[i] = '0; m_mode[i] = '0;
        end
        m_mask = 4'hF; m_cmd = '0; m_tc = '0; m_ff = 1'b0;
    endtask

    task automatic check_outputs(input string tag);
        logic [63:0] eba, ebc, eca, ecc;
        logic [23:0] emd;
        for (int i = 0; i < 4; i++) begin
            eba[i*16 +: 16] = m_ba[i]; ebc[i*16 +: 16] = m_bc[i];
            eca[i*16 +: 16] = m_ca[i]; ecc[i*16 +: 16] = m_cc[i];
            emd[i*6 +: 6]   = m_mode[i];
        end
        check8(tag, "R3 base_addr", ch_base_addr, eba);
        check8(tag, "R3 base_cnt", ch_base_cnt, ebc);
        check8(tag, "R4 cur_addr", ch_cur_addr, eca);
        check8(tag, "R4 cur_cnt", ch_cur_cnt, ecc);
        check8(tag, "R7 mode", {40'd0, ch_mode}, {40'd0, emd});
        check8(tag, "R5 mask", {60'd0, ch_mask}, {60'd0, m_mask});
        check8(tag, "R8 cmd", {56'd0, ch_cmd}, {56'd0, m_cmd});
    endtask

    task automatic op(input string tag, input logic [3:0] off, input logic wr, input logic rd,
                      input logic [7:0] wd, input logic [3:0] tc, input logic [3:0] req,
                      input logic [3:0] upd, input logic [63:0] ua, input logic [63:0] uc,
                      input bit full);
        logic [7:0] e;
        @(negedge clk);
        cpu_off = off; cpu_wr = wr; cpu_rd = rd; cpu_wdata = wd;
        eng_tc = tc; eng_req = req; eng_upd = upd; eng_cur_addr = ua; eng_cur_cnt = uc;
        #1;
        e = (rd && !wr) ? exp_rd(off, req) : 8'h00;
        check8(tag, "rdata", {56'd0, cpu_rdata}, {56'd0, e});
        @(posedge clk);
        // model update
        if (rd && !wr) begin
            if (!off[3]) m_ff = ~m_ff;
            if (off == 4'h8) m_tc = '0;
        end
        for (int c = 0; c < 4; c++)
            if (upd[c] && !(wr && !off[3] && off[2:1] == c[1:0])) begin
                m_ca[c] = ua[c*16 +: 16]; m_cc[c] = uc[c*16 +: 16];
            end
        if (wr) begin
            case (off)
                4'h8: m_cmd = wd;
                4'hA: m_mask[wd[1:0]] = wd[2];
                4'hB: m_mode[wd[1:0]] = wd[7:2];
                4'hC: m_ff = 1'b0;
                4'hD: begin m_ff = 1'b0; m_cmd = '0; m_tc = '0; m_mask = 4'hF;
                            for (int c = 0; c < 4; c++) m_mode[c] = '0; end
                4'hE: m_mask = '0;
                4'hF: m_mask = wd[3:0];
                4'h9: ;
                default: begin
                    if (off[0]) begin
                        if (m_ff) begin m_bc[off[2:1]][15:8] = wd; m_cc[off[2:1]][15:8] = wd; end
                        else      begin m_bc[off[2:1]][7:0]  = wd; m_cc[off[2:1]][7:0]  = wd; end
                    end else begin
                        if (m_ff) begin m_ba[off[2:1]][15:8] = wd; m_ca[off[2:1]][15:8] = wd; end
                        else      begin m_ba[off[2:1]][7:0]  = wd; m_ca[off[2:1]][7:0]  = wd; end
                    end
                    m_ff = ~m_ff;
                end
            endcase
        end
        m_tc = m_tc | tc;
        #1;
        cpu_wr = 1'b0; cpu_rd = 1'b0; eng_tc = '0; eng_upd = '0;
        if (full) check_outputs(tag);
    endtask

    task automatic wr8(input string tag, input logic [3:0] off, input logic [7:0] wd);
        op(tag, off, 1'b1, 1'b0, wd, 4'h0, 4'h0, 4'h0, 64'd0, 64'd0, 1'b1);
    endtask

    task automatic rd8(input string tag, input logic [3:0] off, input logic [3:0] req);
        op(tag, off, 1'b0, 1'b1, 8'h00, 4'h0, req, 4'h0, 64'd0, 64'd0, 1'b1);
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        model_reset();
        #9 rst_n = 1'b1;
        #1;
        // R1 reset state
        check_outputs("R1");
        rd8("R1", 4'h0, 4'h0);
        rd8("R1", 4'h0, 4'h0);

        // R3 address write then readback on channel 1
        wr8("R2", 4'hC, 8'h00);
        wr8("R3", 4'h2, 8'h34);
        wr8("R3", 4'h2, 8'h12);
        rd8("R3", 4'h2, 4'h0);
        rd8("R3", 4'h2, 4'h0);
        // R2 reset of byte select mid-pair
        wr8("R2", 4'h3, 8'hAA);
        wr8("R2", 4'hC, 8'h55);
        wr8("R2", 4'h3, 8'hBB);
        wr8("R2", 4'hC, 8'h00);
        rd8("R2", 4'h3, 4'h0);
        rd8("R2", 4'h3, 4'h0);

        // R4 engine update, then collision with a cpu write
        op("R4", 4'h0, 1'b0, 1'b0, 8'h00, 4'h0, 4'h0, 4'b0010,
           64'h0000_0000_BEEF_0000, 64'h0000_0000_0102_0000, 1'b1);
        rd8("R4", 4'h2, 4'h0);
        rd8("R4", 4'h2, 4'h0);
        op("R4", 4'h3, 1'b1, 1'b0, 8'h77, 4'h0, 4'h0, 4'b0110,
           64'h0000_1111_2222_0000, 64'h0000_3333_4444_0000, 1'b1);
        wr8("R2", 4'hC, 8'h00);

        // R5 single mask, R6 clear all / write all
        wr8("R5", 4'hA, 8'h01);
        wr8("R5", 4'hA, 8'h06);
        wr8("R6", 4'hE, 8'hFF);
        wr8("R6", 4'hF, 8'h0A);
        wr8("R5", 4'hA, 8'h07);

        // R7 modes
        wr8("R7", 4'hB, 8'h46);
        wr8("R7", 4'hB, 8'hC1);
        wr8("R7", 4'hB, 8'h5B);
        // R8 command
        wr8("R8", 4'h8, 8'h5A);

        // R9 terminal count latch and read clear with coincident pulse
        op("R9", 4'h0, 1'b0, 1'b0, 8'h00, 4'b0010, 4'hA, 4'h0, 64'd0, 64'd0, 1'b1);
        op("R9", 4'h8, 1'b0, 1'b1, 8'h00, 4'b1000, 4'hA, 4'h0, 64'd0, 64'd0, 1'b1);
        rd8("R9", 4'h8, 4'h5);
        rd8("R9", 4'h8, 4'h0);

        // R11 unreadable offsets and ignored request write
        wr8("R11", 4'h9, 8'hFF);
        for (int o = 9; o < 16; o++) rd8("R11", o[3:0], 4'hF);
        rd8("R11", 4'h2, 4'h0);

        // R12 simultaneous write and read
        op("R12", 4'h4, 1'b1, 1'b1, 8'h9C, 4'h0, 4'h3, 4'h0, 64'd0, 64'd0, 1'b1);
        rd8("R12", 4'h4, 4'h0);

        // R10 master clear keeps addresses
        op("R10", 4'h0, 1'b0, 1'b0, 8'h00, 4'b0100, 4'h0, 4'h0, 64'd0, 64'd0, 1'b1);
        wr8("R10", 4'hD, 8'h00);
        rd8("R10", 4'h8, 4'h0);
        rd8("R10", 4'h2, 4'h0);

        // random phase
        for (int n = 0; n < 4000; n++) begin
            logic [3:0] off;
            logic       w, r;
            string      t;
            off = 4'($urandom_range(0, 15));
            w = ($urandom_range(0, 2) == 0);
            r = !w || ($urandom_range(0, 15) == 0);
            t = !off[3] ? "R3" : (off == 4'h8) ? "R9" : "R11";
            op(t, off, w, r, 8'($urandom),
               ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'h0,
               4'($urandom),
               ($urandom_range(0, 5) == 0) ? 4'($urandom) : 4'h0,
               {$urandom, $urandom}, {$urandom, $urandom},
               (n % 8) == 0);
        end
        check_outputs("R4");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule